// File: doc/BRIEF.md
# Register/Immediate Arithmetic-Logic Unit

This block is the combinational execute stage of a simple 32-bit load/store processor. It takes two register operands, or one register operand and a 16-bit immediate field, and produces a 32-bit result. A 4-bit operation code selects the function. The available functions are:

- add and subtract;
- the four bitwise functions: AND, OR, XOR and NOR;
- signed set-on-less-than;
- the immediate forms of add, AND, OR, XOR and set-on-less-than;
- load-upper-immediate;
- effective-address generation for loads and stores.

The immediate is always sign-extended, including for the logical functions. The set-on-less-than and upper-immediate results reach the output through a dedicated result multiplexer, next to the adder and the logic unit. A zero flag and an overflow flag go with the result. Add and subtract wrap modulo 2^32 and never trap. The block holds no state.

Internally, a small decoder turns the operation code into a packed struct of strobes: immediate select, subtract, logic function and output select. A datapath module consumes that struct.

Top module: `imm_alu`

## Requirements
- R1: Code 0 gives regA+regB and code 1 gives regA-regB, both modulo 2^32; immVal has no effect on either.
- R2: Codes 2, 3, 4 and 5 give regA AND regB, OR, XOR and NOR (the complement of the OR), respectively.
- R3: Codes 7, 8, 9 and 10 give regA combined by add, AND, OR and XOR with immVal sign-extended from bit 15 to 32 bits; regB has no effect.
- R4: Code 6 gives 1 when regA is less than regB as signed two's-complement numbers, and 0 otherwise, including when the subtraction overflows.
- R5: Code 11 gives 1 when regA is signed-less-than the sign-extended immVal, and 0 otherwise.
- R6: Code 12 gives immVal in bits 31:16 and zeros in bits 15:0.
- R7: Code 13 gives the effective address regA plus the sign-extended immVal.
- R8: ovfFlag is 1 exactly when the signed add or subtract of codes 0, 1, 7 and 13 overflows; it is 0 for every other code.
- R9: zeroFlag is 1 exactly when all 32 bits of result are zero.
- R10: Codes 14 and 15 give result 0, with zeroFlag 1 and ovfFlag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see requirements) |
| regA | input | 32 | First register operand / base address |
| regB | input | 32 | Second register operand |
| immVal | input | 16 | Immediate field, treated as signed |
| result | output | 32 | Selected result |
| zeroFlag | output | 1 | Result is all zeros |
| ovfFlag | output | 1 | Signed overflow of the adder for arithmetic codes |

## Verification
The assertions are immediate checks evaluated whenever the combinational logic settles. They assume that every input is a defined 0/1 value at all times, since an unknown operation code would make the decoder's default branch meaningless. The bench drives every input with a known value from time zero, before the first check. It changes inputs only on the falling clock edge and samples the outputs a few nanoseconds later, once the logic has settled.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_AND  = 4'd2,  OP_OR   = 4'd3,
    OP_XOR  = 4'd4,  OP_NOR  = 4'd5,  OP_SLT  = 4'd6,  OP_ADDI = 4'd7,
    OP_ANDI = 4'd8,  OP_ORI  = 4'd9,  OP_XORI = 4'd10, OP_SLTI = 4'd11,
    OP_LUI  = 4'd12, OP_ADDR = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_NOR = 2'd3
  } logic_fn_e;

  typedef enum logic [2:0] {
    OUT_SUM = 3'd0, OUT_LOGIC = 3'd1, OUT_SLT = 3'd2, OUT_UPPER = 3'd3, OUT_NONE = 3'd4
  } out_sel_e;

  typedef struct packed {
    logic      useImm;
    logic      doSub;
    logic_fn_e logicFn;
    out_sel_e  outSel;
  } alu_ctrl_t;

endpackage

// File: rtl/imm_alu_ctrl.sv
module imm_alu_ctrl
  import imm_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{useImm: 1'b0, doSub: 1'b0, logicFn: LG_AND, outSel: OUT_NONE};
    case (alu_op_e'(opSel))
      OP_ADD:  ctrl.outSel = OUT_SUM;
      OP_SUB:  begin ctrl.outSel = OUT_SUM; ctrl.doSub = 1'b1; end
      OP_AND:  begin ctrl.outSel = OUT_LOGIC; ctrl.logicFn = LG_AND; end
      OP_OR:   begin ctrl.outSel = OUT_LOGIC; ctrl.logicFn = LG_OR; end
      OP_XOR:  begin ctrl.outSel = OUT_LOGIC; ctrl.logicFn = LG_XOR; end
      OP_NOR:  begin ctrl.outSel = OUT_LOGIC; ctrl.logicFn = LG_NOR; end
      OP_SLT:  begin ctrl.outSel = OUT_SLT; ctrl.doSub = 1'b1; end
      OP_ADDI: begin ctrl.outSel = OUT_SUM; ctrl.useImm = 1'b1; end
      OP_ANDI: begin ctrl.outSel = OUT_LOGIC; ctrl.logicFn = LG_AND; ctrl.useImm = 1'b1; end
      OP_ORI:  begin ctrl.outSel = OUT_LOGIC; ctrl.logicFn = LG_OR;  ctrl.useImm = 1'b1; end
      OP_XORI: begin ctrl.outSel = OUT_LOGIC; ctrl.logicFn = LG_XOR; ctrl.useImm = 1'b1; end
      OP_SLTI: begin ctrl.outSel = OUT_SLT; ctrl.doSub = 1'b1; ctrl.useImm = 1'b1; end
      OP_LUI:  ctrl.outSel = OUT_UPPER;
      OP_ADDR: begin ctrl.outSel = OUT_SUM; ctrl.useImm = 1'b1; end
      default: ctrl.outSel = OUT_NONE;
    endcase
  end

  // R4/R5: a comparison must always be decoded as a subtraction
  always_comb begin
    if (ctrl.outSel == OUT_SLT)
      p_slt_subtracts_r4: assert (ctrl.doSub)
        else $error("slt decoded without subtract");
  end

endmodule

// File: rtl/imm_alu_dp.sv
module imm_alu_dp
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  alu_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  localparam int MSB    = DATA_W - 1;
  localparam int EXT_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt, opB, addB, sumVal, logicVal, sltVal, upperVal;
  logic              ovfRaw, lessThan;

  assign immExt = {{EXT_W{immVal[IMM_W-1]}}, immVal};
  assign opB    = ctrl.useImm ? immExt : regB;
  assign addB   = ctrl.doSub ? ~opB : opB;
  assign sumVal = regA + addB + {{(DATA_W-1){1'b0}}, ctrl.doSub};

  // signed overflow: like-signed inputs producing an opposite-signed sum
  assign ovfRaw   = (regA[MSB] == addB[MSB]) && (sumVal[MSB] != regA[MSB]);
  assign lessThan = sumVal[MSB] ^ ovfRaw;
  assign sltVal   = {{(DATA_W-1){1'b0}}, lessThan};
  assign upperVal = {immVal, {EXT_W{1'b0}}};

  always_comb begin
    case (ctrl.logicFn)
      LG_AND:  logicVal = regA & opB;
      LG_OR:   logicVal = regA | opB;
      LG_XOR:  logicVal = regA ^ opB;
      default: logicVal = ~(regA | opB);
    endcase
  end

  always_comb begin
    case (ctrl.outSel)
      OUT_SUM:   result = sumVal;
      OUT_LOGIC: result = logicVal;
      OUT_SLT:   result = sltVal;
      OUT_UPPER: result = upperVal;
      default:   result = '0;
    endcase
  end

  assign zeroFlag = ~|result;
  assign ovfFlag  = (ctrl.outSel == OUT_SUM) && ovfRaw;

  // R4/R5: comparison result agrees with an independent signed compare
  always_comb begin
    if (ctrl.outSel == OUT_SLT)
      p_slt_signed_r4: assert (result == {{(DATA_W-1){1'b0}}, ($signed(regA) < $signed(opB))})
        else $error("slt result disagrees with signed compare");
  end

  // R6: upper-immediate leaves the low half clear
  always_comb begin
    if (ctrl.outSel == OUT_UPPER)
      p_upper_low_clear_r6: assert (result[EXT_W-1:0] == '0)
        else $error("upper immediate low half not zero");
  end

  // R8: overflow only ever reported for adder results
  always_comb begin
    if (ctrl.outSel != OUT_SUM)
      p_no_overflow_r8: assert (!ovfFlag)
        else $error("overflow flag set on non-adder result");
  end

  // R10: reserved codes produce a zero result with the zero flag up
  always_comb begin
    if (ctrl.outSel == OUT_NONE)
      p_reserved_zero_r10: assert (zeroFlag && result == '0)
        else $error("reserved code produced nonzero result");
  end

endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  alu_ctrl_t ctrl;

  imm_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  imm_alu_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .ctrl     (ctrl),
    .regA     (regA),
    .regB     (regB),
    .immVal   (immVal),
    .result   (result),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: tb/imm_alu_test.sv
module imm_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opSel = 4'd0;
  logic [31:0] regA = '0, regB = '0;
  logic [15:0] immVal = '0;
  logic [31:0] result;
  logic        zeroFlag, ovfFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  imm_alu uut (
    .opSel(opSel), .regA(regA), .regB(regB), .immVal(immVal),
    .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm);
    @(negedge clk);
    opSel = op; regA = a; regB = b; immVal = imm;
    #3;
  endtask

  task automatic run_idle;
    apply(4'd0, 32'd0, 32'd0, 16'd0);
    check("R9 idle result", result, 32'd0);
    check("R9 idle zero", {31'd0, zeroFlag}, 32'd1);
    check("R8 idle ovf", {31'd0, ovfFlag}, 32'd0);
  endtask

  task automatic run_r1_r8_arith;
    apply(4'd0, 32'h7fffffff, 32'd1, 16'hffff);
    check("R1 add wrap", result, 32'h80000000);
    check("R8 add ovf", {31'd0, ovfFlag}, 32'd1);
    apply(4'd1, 32'd5, 32'd7, 16'h1234);
    check("R1 sub negative", result, 32'hfffffffe);
    check("R8 sub no ovf", {31'd0, ovfFlag}, 32'd0);
    apply(4'd0, 32'hffffffff, 32'd1, 16'h0000);
    check("R1 add carry out", result, 32'd0);
    check("R9 zero after wrap", {31'd0, zeroFlag}, 32'd1);
    check("R8 carry is not ovf", {31'd0, ovfFlag}, 32'd0);
    apply(4'd1, 32'h80000000, 32'd1, 16'h0000);
    check("R1 sub wrap", result, 32'h7fffffff);
    check("R8 sub ovf", {31'd0, ovfFlag}, 32'd1);
  endtask

  task automatic run_r2_logic;
    logic [31:0] a = 32'hf0f01234, b = 32'h0ff0ff00;
    apply(4'd2, a, b, 16'hffff); check("R2 and", result, a & b);
    apply(4'd3, a, b, 16'hffff); check("R2 or",  result, a | b);
    apply(4'd4, a, b, 16'hffff); check("R2 xor", result, a ^ b);
    apply(4'd5, a, b, 16'hffff); check("R2 nor", result, ~(a | b));
    check("R9 nonzero", {31'd0, zeroFlag}, 32'd0);
    apply(4'd4, a, a, 16'h0000); check("R9 xor self zero", {31'd0, zeroFlag}, 32'd1);
  endtask

  task automatic run_r3_imm;
    logic [31:0] a = 32'h12345678, junk = 32'hdeadbeef;
    apply(4'd7, 32'd10, junk, 16'hfffb); check("R3 addi neg", result, 32'd5);
    apply(4'd8, a, junk, 16'h8001); check("R3 andi sext", result, a & sx(16'h8001));
    apply(4'd9, a, junk, 16'h8001); check("R3 ori sext",  result, a | sx(16'h8001));
    apply(4'd10, a, junk, 16'h00ff); check("R3 xori pos", result, a ^ 32'h000000ff);
    apply(4'd10, a, junk, 16'hff00); check("R3 xori sext", result, a ^ 32'hffffff00);
    apply(4'd7, 32'h7fffffff, junk, 16'h0001);
    check("R8 addi ovf", {31'd0, ovfFlag}, 32'd1);
  endtask

  task automatic run_r4_slt;
    apply(4'd6, 32'hffffffff, 32'd1, 16'h0); check("R4 -1<1", result, 32'd1);
    apply(4'd6, 32'd1, 32'hffffffff, 16'h0); check("R4 1<-1", result, 32'd0);
    apply(4'd6, 32'h80000000, 32'h7fffffff, 16'h0); check("R4 ovf case", result, 32'd1);
    check("R8 slt no ovf", {31'd0, ovfFlag}, 32'd0);
    apply(4'd6, 32'h7fffffff, 32'h80000000, 16'h0); check("R4 ovf reverse", result, 32'd0);
    apply(4'd6, 32'd42, 32'd42, 16'h0); check("R4 equal", result, 32'd0);
  endtask

  task automatic run_r5_slti;
    apply(4'd11, 32'hfffffffd, 32'd0, 16'hfffe); check("R5 -3<-2", result, 32'd1);
    apply(4'd11, 32'd5, 32'hffffffff, 16'h0005); check("R5 5<5", result, 32'd0);
    apply(4'd11, 32'd0, 32'd0, 16'h8000); check("R5 0<-32768", result, 32'd0);
  endtask

  task automatic run_r6_lui;
    apply(4'd12, 32'hffffffff, 32'hffffffff, 16'hbeef);
    check("R6 lui", result, 32'hbeef0000);
    check("R8 lui no ovf", {31'd0, ovfFlag}, 32'd0);
  endtask

  task automatic run_r7_addr;
    apply(4'd13, 32'h00001000, 32'hffffffff, 16'hfff8); check("R7 neg offset", result, 32'h00000ff8);
    apply(4'd13, 32'h00001000, 32'd0, 16'h0040); check("R7 pos offset", result, 32'h00001040);
  endtask

  task automatic run_r10_reserved;
    apply(4'd14, 32'h7fffffff, 32'd1, 16'h1234);
    check("R10 code14 result", result, 32'd0);
    check("R10 code14 zero", {31'd0, zeroFlag}, 32'd1);
    apply(4'd15, 32'h80000000, 32'h80000000, 16'hffff);
    check("R10 code15 result", result, 32'd0);
    check("R10 code15 ovf", {31'd0, ovfFlag}, 32'd0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    run_idle;
    run_r1_r8_arith;
    run_r2_logic;
    run_r3_imm;
    run_r4_slt;
    run_r5_slti;
    run_r6_lui;
    run_r7_addr;
    run_r10_reserved;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule